// File: doc/BRIEF.md
# Trace-Back Survivor Memory

This block is the survivor-path stage of a Viterbi decoder. Each trellis step the add-compare-select stage hands it one decision vector, with one bit per state that tells which of the two predecessors survived. The vectors are written into a circular buffer of `MERGE_LEN + 2*DECODE_LEN` columns. The column index is the time index, and bit `s` of a column is the decision for state `s`.

Every time a further block of `DECODE_LEN` vectors has been written, a trace-back engine walks backward from the newest column, starting in state 0. The first `MERGE_LEN` steps only let the survivor paths converge, and their bits are dropped. The next `DECODE_LEN` steps yield decoded bits, newest first. These bits go into one half of a two-bank LIFO, and the other half is emitted oldest first as a burst on `bitOut`. The engine takes `STEPS` steps per cycle, so it can keep up with one input per cycle. If it still falls behind, `inReady` drops at a block boundary until it catches up.

Top module: `survivor_trace`

## Requirements
- R1: A vector is accepted on a rising clock edge with `decValid` and `inReady` both high. Accepted vectors go to consecutive columns modulo `MERGE_LEN + 2*DECODE_LEN`, and bit `s` of the vector is the decision for state `s`.
- R2: After reset, a trace starts when the number of accepted vectors first reaches `MERGE_LEN + DECODE_LEN`, and again after each further `DECODE_LEN` vectors. Each trace starts at the newest accepted column in state 0.
- R3: A trace step at column `c` in state `s` works as follows. The decoded bit for `c` is `s[0]`. The step then reads decision bit `b` of column `c` at position `s`. The next state is `{b, s[K-1:1]}`, with `K = log2(NUM_STATES)`, and the next column is `c-1`, wrapping circularly.
- R4: The first `MERGE_LEN` steps of a trace produce no output. The following `DECODE_LEN` steps produce exactly the decoded bits of the `DECODE_LEN` oldest columns in the trace window.
- R5: The bits of one trace leave as one burst of exactly `DECODE_LEN` consecutive `bitValid` cycles, oldest column first. At least one idle cycle separates two bursts.
- R6: `bitValid` stays low until at least `MERGE_LEN + DECODE_LEN` vectors have been accepted since reset.
- R7: A cycle with `inReady` low or with `decValid` low writes nothing. The `decVec` value driven in such a cycle never reaches the output. Under a continuous input stream the block applies back-pressure when the trace engine lags.
- R8: While reset is asserted and in the first cycle after it, `bitValid` and `bitOut` are 0 and `inReady` is 1.
- R9: `inReady` goes low only when the number of vectors accepted since reset, modulo `DECODE_LEN`, is 0 or `DECODE_LEN-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| decValid | input | 1 | Marks `decVec` as a valid decision vector |
| decVec | input | NUM_STATES | Decision bits, bit s is the survivor choice for state s |
| inReady | output | 1 | Vector is taken this cycle when high, otherwise the input is held off |
| bitOut | output | 1 | Decoded bit |
| bitValid | output | 1 | Marks `bitOut` as valid |

## Verification
The bench uses uniform decision vectors whose trace walks are worked out by hand. It compares the resulting 16-bit output words against those walks, so a wrong state-update bit order, a trace starting state other than 0, or a wrong merge depth changes the word. A bench model re-walks every trace window from the recorded vectors. This model catches bits emitted newest first, bits from the wrong window, and a trace started one column off. A long gap-free stream forces back-pressure, and in stall cycles the bench drives the inverted vector. A design that wrote while stalled, or stalled mid-block and let the writer overrun a column still under trace, would then emit mismatching bits or the wrong bit count.

// File: rtl/survivor_trace_pkg.sv
package survivor_trace_pkg;

  // Phase of the trace-back engine
  typedef enum logic [1:0] {
    TR_IDLE = 2'd0,
    TR_RUN  = 2'd1,
    TR_HOLD = 2'd2
  } trPhase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // store decVec at wrCol
    logic trLoad;    // start a trace at newestCol, state 0
    logic trStep;    // advance the trace by STEPS steps
    logic trDecode;  // the current steps lie in the decode region
    logic fillBank;  // LIFO bank receiving decoded bits
    logic popEn;     // emit one bit from the draining bank
    logic popBank;   // LIFO bank being drained
  } trCtl_t;

endpackage

// File: rtl/survivor_trace_ctrl.sv
module survivor_trace_ctrl
  import survivor_trace_pkg::*;
#(
  parameter int MERGE_LEN  = 16,
  parameter int DECODE_LEN = 16,
  parameter int STEPS      = 2,
  localparam int NCOL      = MERGE_LEN + 2 * DECODE_LEN,
  localparam int COL_W     = $clog2(NCOL),
  localparam int D_W       = $clog2(DECODE_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             decValid,
  output logic             inReady,
  output trCtl_t           ctl,
  output logic [COL_W-1:0] wrCol,
  output logic [COL_W-1:0] newestCol,
  output logic [D_W-1:0]   decBase,
  output logic [D_W-1:0]   popIdx
);

  localparam int SPAN      = MERGE_LEN + DECODE_LEN;
  localparam int STEP_W    = $clog2(SPAN + 1);
  localparam int FIRST_BLK = MERGE_LEN / DECODE_LEN;
  localparam int BLK_W     = $clog2(FIRST_BLK + 1);

  // write side
  logic [COL_W-1:0] wrColQ;
  logic [D_W-1:0]   wrInBlkQ;
  logic [BLK_W-1:0] blkCntQ;
  // trace request slot
  logic             pendQ;
  logic [COL_W-1:0] pendColQ;
  // trace engine
  trPhase_e         phaseQ;
  logic [STEP_W-1:0] stepQ;
  logic             fillBankQ;
  // LIFO drain side
  logic             popBusyQ;
  logic             popBankQ;
  logic [D_W-1:0]   popIdxQ;

  logic haveWindow, blockStart, blockEnd, outstandingTwo;
  logic accept, request, startTr, lastStep, handover;

  assign haveWindow     = (blkCntQ == BLK_W'(FIRST_BLK));
  assign blockStart     = (wrInBlkQ == '0);
  assign blockEnd       = (wrInBlkQ == D_W'(DECODE_LEN - 1));
  assign outstandingTwo = pendQ && (phaseQ != TR_IDLE);

  // Back-pressure only at block edges:
  //  - entering a block while two traces are outstanding could overwrite
  //    columns an older trace still has to read
  //  - closing a block while the request slot is occupied would lose a trace
  assign inReady = !((blockStart && outstandingTwo) ||
                     (blockEnd && haveWindow && pendQ));

  assign accept   = decValid && inReady;
  assign request  = accept && blockEnd && haveWindow;
  assign startTr  = (phaseQ == TR_IDLE) && pendQ;
  assign lastStep = (phaseQ == TR_RUN) && (stepQ == STEP_W'(SPAN - STEPS));
  assign handover = (lastStep || (phaseQ == TR_HOLD)) && !popBusyQ;

  // write pointer and block bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrColQ   <= '0;
      wrInBlkQ <= '0;
      blkCntQ  <= '0;
    end else if (accept) begin
      wrColQ   <= (wrColQ == COL_W'(NCOL - 1)) ? '0 : wrColQ + 1'b1;
      wrInBlkQ <= blockEnd ? '0 : wrInBlkQ + 1'b1;
      if (blockEnd && !haveWindow) blkCntQ <= blkCntQ + 1'b1;
    end
  end

  // single-entry request slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= 1'b0;
      pendColQ <= '0;
    end else if (request) begin
      pendQ    <= 1'b1;
      pendColQ <= wrColQ;
    end else if (startTr) begin
      pendQ    <= 1'b0;
    end
  end

  // trace engine sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= TR_IDLE;
      stepQ  <= '0;
    end else begin
      case (phaseQ)
        TR_IDLE: begin
          if (pendQ) begin
            phaseQ <= TR_RUN;
            stepQ  <= '0;
          end
        end
        TR_RUN: begin
          stepQ <= stepQ + STEP_W'(STEPS);
          if (lastStep) phaseQ <= popBusyQ ? TR_HOLD : TR_IDLE;
        end
        TR_HOLD: begin
          if (!popBusyQ) phaseQ <= TR_IDLE;
        end
        default: phaseQ <= TR_IDLE;
      endcase
    end
  end

  // ping-pong LIFO banks: fill one while the other drains
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillBankQ <= 1'b0;
      popBankQ  <= 1'b0;
      popBusyQ  <= 1'b0;
      popIdxQ   <= '0;
    end else if (handover) begin
      fillBankQ <= ~fillBankQ;
      popBankQ  <= fillBankQ;
      popBusyQ  <= 1'b1;
      popIdxQ   <= D_W'(DECODE_LEN - 1);
    end else if (popBusyQ) begin
      popIdxQ <= popIdxQ - 1'b1;
      if (popIdxQ == '0) popBusyQ <= 1'b0;
    end
  end

  always_comb begin
    ctl.wrEn     = accept;
    ctl.trLoad   = startTr;
    ctl.trStep   = (phaseQ == TR_RUN);
    ctl.trDecode = (phaseQ == TR_RUN) && (stepQ >= STEP_W'(MERGE_LEN));
    ctl.fillBank = fillBankQ;
    ctl.popEn    = popBusyQ;
    ctl.popBank  = popBankQ;
  end

  assign wrCol     = wrColQ;
  assign newestCol = pendColQ;
  assign decBase   = D_W'(stepQ - STEP_W'(MERGE_LEN));
  assign popIdx    = popIdxQ;

endmodule

// File: rtl/survivor_trace_dp.sv
module survivor_trace_dp
  import survivor_trace_pkg::*;
#(
  parameter int NUM_STATES = 8,
  parameter int MERGE_LEN  = 16,
  parameter int DECODE_LEN = 16,
  parameter int STEPS      = 2,
  localparam int NCOL      = MERGE_LEN + 2 * DECODE_LEN,
  localparam int COL_W     = $clog2(NCOL),
  localparam int D_W       = $clog2(DECODE_LEN),
  localparam int ST_W      = $clog2(NUM_STATES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  trCtl_t                ctl,
  input  logic [NUM_STATES-1:0] decVec,
  input  logic [COL_W-1:0]      wrCol,
  input  logic [COL_W-1:0]      newestCol,
  input  logic [D_W-1:0]        decBase,
  input  logic [D_W-1:0]        popIdx,
  output logic                  bitOut,
  output logic                  bitValid
);

  // decision memory: column = time index, bit = state
  logic [NUM_STATES-1:0] memQ [NCOL];

  always_ff @(posedge clk) begin
    if (ctl.wrEn) memQ[wrCol] <= decVec;
  end

  // trace position
  logic [ST_W-1:0]  curStQ, nxtSt, walkSt;
  logic [COL_W-1:0] curColQ, nxtCol, walkCol;
  logic [STEPS-1:0] stepBits;
  logic             readBit;

  // STEPS unrolled trace steps per cycle
  always_comb begin
    walkSt  = curStQ;
    walkCol = curColQ;
    readBit = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      stepBits[i] = walkSt[0];
      readBit     = memQ[walkCol][walkSt];
      walkSt      = {readBit, walkSt[ST_W-1:1]};
      walkCol     = (walkCol == '0) ? COL_W'(NCOL - 1) : walkCol - 1'b1;
    end
    nxtSt  = walkSt;
    nxtCol = walkCol;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curStQ  <= '0;
      curColQ <= '0;
    end else if (ctl.trLoad) begin
      curStQ  <= '0;
      curColQ <= newestCol;
    end else if (ctl.trStep) begin
      curStQ  <= nxtSt;
      curColQ <= nxtCol;
    end
  end

  // two LIFO banks, indexed by decode step (newest column at index 0)
  logic [DECODE_LEN-1:0] lifoQ [2];

  always_ff @(posedge clk) begin
    if (ctl.trDecode) begin
      for (int i = 0; i < STEPS; i++) begin
        lifoQ[ctl.fillBank][decBase + D_W'(i)] <= stepBits[i];
      end
    end
  end

  // drain from the highest index down: oldest column first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitValid <= 1'b0;
      bitOut   <= 1'b0;
    end else begin
      bitValid <= ctl.popEn;
      bitOut   <= ctl.popEn ? lifoQ[ctl.popBank][popIdx] : 1'b0;
    end
  end

endmodule

// File: rtl/survivor_trace.sv
module survivor_trace
  import survivor_trace_pkg::*;
#(
  parameter int NUM_STATES = 8,
  parameter int MERGE_LEN  = 16,
  parameter int DECODE_LEN = 16,
  parameter int STEPS      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  decValid,
  input  logic [NUM_STATES-1:0] decVec,
  output logic                  inReady,
  output logic                  bitOut,
  output logic                  bitValid
);

  localparam int NCOL  = MERGE_LEN + 2 * DECODE_LEN;
  localparam int COL_W = $clog2(NCOL);
  localparam int D_W   = $clog2(DECODE_LEN);

  trCtl_t           ctl;
  logic [COL_W-1:0] wrCol, newestCol;
  logic [D_W-1:0]   decBase, popIdx;

  survivor_trace_ctrl #(
    .MERGE_LEN (MERGE_LEN),
    .DECODE_LEN(DECODE_LEN),
    .STEPS     (STEPS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .decValid (decValid),
    .inReady  (inReady),
    .ctl      (ctl),
    .wrCol    (wrCol),
    .newestCol(newestCol),
    .decBase  (decBase),
    .popIdx   (popIdx)
  );

  survivor_trace_dp #(
    .NUM_STATES(NUM_STATES),
    .MERGE_LEN (MERGE_LEN),
    .DECODE_LEN(DECODE_LEN),
    .STEPS     (STEPS)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .decVec   (decVec),
    .wrCol    (wrCol),
    .newestCol(newestCol),
    .decBase  (decBase),
    .popIdx   (popIdx),
    .bitOut   (bitOut),
    .bitValid (bitValid)
  );

endmodule

// File: rtl/survivor_trace_chk.sv
module survivor_trace_chk #(
  parameter int MERGE_LEN  = 16,
  parameter int DECODE_LEN = 16
) (
  input logic clk,
  input logic rstN,
  input logic decValid,
  input logic inReady,
  input logic bitValid,
  input logic bitOut
);

  localparam int WIN   = MERGE_LEN + DECODE_LEN;
  localparam int CNT_W = $clog2(WIN + 1);
  localparam int RUN_W = $clog2(DECODE_LEN + 1);

  logic [CNT_W-1:0] accCnt;
  logic [RUN_W-1:0] blkPos;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accCnt <= '0;
      blkPos <= '0;
      runLen <= '0;
    end else begin
      if (decValid && inReady) begin
        if (accCnt != CNT_W'(WIN)) accCnt <= accCnt + 1'b1;
        blkPos <= (blkPos == RUN_W'(DECODE_LEN - 1)) ? '0 : blkPos + 1'b1;
      end
      runLen <= bitValid ? runLen + 1'b1 : '0;
    end
  end

  // R8
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!bitValid && !bitOut && inReady));

  // R6
  first_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (accCnt == CNT_W'(WIN)));

  // R9
  stall_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> (blkPos == '0 || blkPos == RUN_W'(DECODE_LEN - 1)));

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (runLen < RUN_W'(DECODE_LEN)));

  // R5
  burst_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bitValid) |-> (runLen == RUN_W'(DECODE_LEN)));

endmodule

bind survivor_trace survivor_trace_chk #(
  .MERGE_LEN (MERGE_LEN),
  .DECODE_LEN(DECODE_LEN)
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .decValid(decValid),
  .inReady (inReady),
  .bitValid(bitValid),
  .bitOut  (bitOut)
);

// File: tb/test_survivor_trace.sv
`timescale 1ns/1ps
module test_survivor_trace;

  localparam int NS    = 8;
  localparam int L     = 16;
  localparam int D     = 16;
  localparam int STEPS = 2;
  localparam int ST_W  = $clog2(NS);

  // entry: [23:16] decision vector repeated in every column,
  //        [15:0]  first decoded word, bit i = i-th emitted bit
  localparam logic [23:0] VEC_TABLE [7] = '{
    24'h00_0000,
    24'hFF_FFFF,
    24'h01_1111,
    24'h80_0000,
    24'hFE_0000,
    24'h7F_DDDD,
    24'h03_2492
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic decValid = 1'b0;
  logic [NS-1:0] decVec = '0;
  logic inReady, bitOut, bitValid;

  always #5 clk = ~clk;

  survivor_trace #(
    .NUM_STATES(NS),
    .MERGE_LEN (L),
    .DECODE_LEN(D),
    .STEPS     (STEPS)
  ) i_survivor_trace (
    .clk     (clk),
    .rstN    (rstN),
    .decValid(decValid),
    .decVec  (decVec),
    .inReady (inReady),
    .bitOut  (bitOut),
    .bitValid(bitValid)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [NS-1:0] accVec [0:4095];
  int accN = 0;
  int stallSeen = 0;
  bit expQ[$];
  bit gotQ[$];
  bit expBit;
  logic [15:0] word;
  logic [7:0] lfsr;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference walk of one trace window ending at the newest column (R2, R3, R4)
  function automatic void addBlock();
    int newest = accN - 1;
    logic [ST_W-1:0] s = '0;
    logic [D-1:0] tmp = '0;
    for (int k = 0; k < L + D; k++) begin
      if (k >= L) tmp[k-L] = s[0];
      s = {accVec[newest-k][s], s[ST_W-1:1]};
    end
    for (int j = D - 1; j >= 0; j--) expQ.push_back(tmp[j]);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    decValid = 1'b0;
    decVec = '0;
    accN = 0;
    stallSeen = 0;
    expQ.delete();
    gotQ.delete();
    repeat (3) @(negedge clk);
    // R8 during reset
    check(!bitValid && !bitOut && inReady, "R8 outputs in reset",
          {bitValid, bitOut, inReady}, 3'b001);
    rstN = 1'b1;
  endtask

  // present v until taken; stall cycles carry the inverted vector (R7)
  task automatic putVec(input logic [NS-1:0] v);
    bit taken = 0;
    while (!taken) begin
      @(negedge clk);
      decValid = 1'b1;
      if (inReady) begin
        decVec = v;
        taken = 1;
        accVec[accN] = v;
        accN++;
        if ((accN % D == 0) && (accN >= L + D)) addBlock();
      end else begin
        decVec = ~v;
        stallSeen++;
        check((accN % D == 0) || (accN % D == D - 1), "R9 stall position",
              accN % D, 0);
      end
    end
  endtask

  // idle cycle with junk on decVec (R7)
  task automatic idleCycle();
    @(negedge clk);
    decValid = 1'b0;
    decVec = 8'hA5;
  endtask

  // output collector
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && bitValid) begin
        check(accN >= L + D, "R6 output before window filled", accN, L + D);
        if (expQ.size() == 0) begin
          check(1'b0, "R4 R5 unexpected output bit", 1, 0);
        end else begin
          expBit = expQ.pop_front();
          check(bitOut == expBit, "R1 R3 R5 R7 decoded bit", bitOut, expBit);
        end
        gotQ.push_back(bitOut);
      end
    end
  end

  // watchdog
  initial begin
    #(100000 * 10);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog R5 run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    // R8 first cycle after reset
    check(!bitValid && !bitOut && inReady, "R8 outputs after reset",
          {bitValid, bitOut, inReady}, 3'b001);

    // table walk: uniform columns, hand-derived first words (R2 R3 R4 R5)
    for (int t = 0; t < 7; t++) begin
      doReset();
      for (int n = 0; n < 2 * D; n++) putVec(VEC_TABLE[t][23:16]);
      idleCycle();
      for (int c = 0; c < 200 && gotQ.size() < D; c++) @(negedge clk);
      word = '0;
      for (int i = 0; i < D && i < gotQ.size(); i++) word[i] = gotQ[i];
      check(word == VEC_TABLE[t][15:0], "R2 R3 R4 table word", word,
            VEC_TABLE[t][15:0]);
    end

    // pseudo-random vectors with idle gaps
    doReset();
    lfsr = 8'h5A;
    for (int n = 0; n < 10 * D; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      putVec(lfsr);
      if (n % 7 == 6) idleCycle();
    end
    idleCycle();
    repeat (150) @(negedge clk);
    check(expQ.size() == 0, "R5 all expected bits emitted", expQ.size(), 0);
    check(gotQ.size() == 9 * D, "R4 bit count with gaps", gotQ.size(), 9 * D);

    // continuous stream: engine lags and back-pressure appears
    doReset();
    lfsr = 8'hC3;
    for (int n = 0; n < 40 * D; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      putVec(lfsr);
    end
    idleCycle();
    repeat (150) @(negedge clk);
    check(stallSeen > 0, "R7 back-pressure under full rate", stallSeen, 1);
    check(expQ.size() == 0, "R5 stream drained", expQ.size(), 0);
    check(gotQ.size() == 39 * D, "R1 R2 stream bit count", gotQ.size(), 39 * D);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule